// File: doc/BRIEF.md
# Descriptor-Chain DMA Queue Engine

This block is one direction of a DMA queue. It follows a linked list of packet descriptors held in memory. A start command gives it the address of the first descriptor. For each descriptor it reads the header word and checks the ownership flag. If hardware owns the descriptor, the engine reads the rest of the descriptor, streams the referenced data buffer out word by word, and clears the ownership flag in memory so software gets the descriptor back. It then moves to the next descriptor in the chain.

The engine stops at the first descriptor it does not own and reports that the queue is empty. Its current address still points at that descriptor, so a later resume command continues from there once software has filled it. A buffer length outside the legal range also stops the queue and raises a sticky error flag.

The memory side is one port with a request/acknowledge handshake. Each access moves a 32-bit word and carries byte enables. A completion pulse marks each finished descriptor that asked for one.

Top module: `dq_queue_engine`

## Requirements
- R1: After reset `busy_o`, `err_o`, `done_o`, `empty_o`, `stream_valid_o` and `mem_req_o` are low and `cur_addr_o` is zero. No memory request is made while the engine is idle.
- R2: A start pulse given while idle loads the start address with its low four bits cleared into the current address. Fetching begins there.
- R3: A descriptor is six little-endian 32-bit words at offsets 0, 4, 8, 12, 16 and 20 from its base. Word 0 holds the flags in bits [7:0] and the receive allowance in bits [31:16]. Word 1 holds the high half of the next pointer and word 2 the low half. Word 3 holds the high half of the buffer pointer and word 4 the low half. Word 5 holds the buffer length in bytes in bits [15:0]. Each memory request holds its address stable until it is acknowledged.
- R4: For an owned descriptor with a valid length L, the engine reads ceil(L/4) words in ascending order, starting at the buffer pointer with its low two bits cleared. Each word appears as a one-cycle `stream_valid_o` beat. `stream_last_o` is set only on the final word.
- R5: After the last buffer word, the engine writes word 0 of the descriptor with byte enable 4'b0001. Flags bit 0 (hardware owns) is cleared. The other flag bits and the other three bytes of the word are left unchanged.
- R6: `done_o` pulses for one cycle after that write-back only when flags bit 7 (interrupt on completion) is set.
- R7: After the write-back, the current address becomes the next pointer with its low four bits cleared, and fetching continues there.
- R8: When a fetched header has bit 0 clear, the engine pulses `empty_o` once and goes idle. `cur_addr_o` stays at that descriptor. No data is moved and nothing is written back.
- R9: A resume pulse given while idle restarts fetching at `cur_addr_o`, not at the last start address.
- R10: A buffer length of zero or above MAX_LEN sets `err_o` and halts the queue at that descriptor. No data is streamed and no write-back happens. `err_o` stays set until the next start or resume.
- R11: Start and resume pulses are ignored while the engine is busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Load start address and run |
| start_addr_i | input | ADDR_W | First descriptor address |
| resume_i | input | 1 | Run from current address |
| busy_o | output | 1 | Engine is walking the chain |
| cur_addr_o | output | ADDR_W | Address of the descriptor being processed or halted on |
| err_o | output | 1 | Sticky illegal-length flag |
| done_o | output | 1 | Completion pulse for a descriptor that requested one |
| empty_o | output | 1 | Pulse on reaching a descriptor owned by software |
| stream_valid_o | output | 1 | Data word valid |
| stream_data_o | output | 32 | Data word |
| stream_last_o | output | 1 | Final word of a buffer |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | ADDR_W | Byte address |
| mem_be_o | output | 4 | Byte enables |
| mem_wdata_o | output | 32 | Write data |
| mem_ack_i | input | 1 | Access complete, read data valid |
| mem_rdata_i | input | 32 | Read data |

## Verification
The bench builds the engine with MAX_LEN set to 64 and ADDR_W left at 64. With this small limit, both edges of the length check (64 accepted, 65 rejected) can be reached with 16-word buffers. Random chains can also cover the whole legal length range in a few hundred cycles. The memory model adds random acknowledge latency. Chains use misaligned start, next and buffer pointers to exercise address masking.

// File: rtl/dq_pkg.sv
package dq_pkg;
  localparam int DQ_WORD_W     = 32;
  localparam int DQ_DESC_WORDS = 6;
  localparam int DQ_FLAG_OWN   = 0;
  localparam int DQ_FLAG_IOC   = 7;

  typedef struct packed {
    logic [7:0]  flags;
    logic [15:0] rx_len;
    logic [63:0] next_ptr;
    logic [63:0] buf_ptr;
    logic [15:0] buf_len;
  } dq_desc_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_DESC,
    ST_CHK,
    ST_BUF,
    ST_WB
  } dq_state_e;
endpackage

// File: rtl/dq_desc_regs.sv
module dq_desc_regs
  import dq_pkg::*;
#(
  parameter int IDX_W = $clog2(DQ_DESC_WORDS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cap_i,
  input  logic [IDX_W-1:0]     idx_i,
  input  logic [DQ_WORD_W-1:0] data_i,
  output dq_desc_t             desc_o
);
  logic [7:0]  flags_q;
  logic [15:0] rxl_q, len_q;
  logic [31:0] nhi_q, nlo_q, bhi_q, blo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
      rxl_q   <= '0;
      nhi_q   <= '0;
      nlo_q   <= '0;
      bhi_q   <= '0;
      blo_q   <= '0;
      len_q   <= '0;
    end else if (cap_i) begin
      case (idx_i)
        IDX_W'(0): begin
          flags_q <= data_i[7:0];
          rxl_q   <= data_i[31:16];
        end
        IDX_W'(1): nhi_q <= data_i;
        IDX_W'(2): nlo_q <= data_i;
        IDX_W'(3): bhi_q <= data_i;
        IDX_W'(4): blo_q <= data_i;
        IDX_W'(5): len_q <= data_i[15:0];
        default: ;
      endcase
    end
  end

  assign desc_o = '{flags:    flags_q,
                    rx_len:   rxl_q,
                    next_ptr: {nhi_q, nlo_q},
                    buf_ptr:  {bhi_q, blo_q},
                    buf_len:  len_q};
endmodule

// File: rtl/dq_len_check.sv
module dq_len_check #(
  parameter int LEN_W   = 16,
  parameter int MAX_LEN = 3584,
  parameter int BYTES_W = 4
) (
  input  logic [LEN_W-1:0] len_i,
  output logic             ok_o,
  output logic [LEN_W-1:0] words_o
);
  localparam int               SH    = $clog2(BYTES_W);
  localparam logic [LEN_W:0]   LIMIT = (LEN_W+1)'(MAX_LEN);

  logic [LEN_W:0] rnd;

  assign rnd     = {1'b0, len_i} + (LEN_W+1)'(BYTES_W - 1);
  assign words_o = LEN_W'(rnd >> SH);
  assign ok_o    = (len_i != '0) && ({1'b0, len_i} <= LIMIT);
endmodule

// File: rtl/dq_queue_engine.sv
module dq_queue_engine
  import dq_pkg::*;
#(
  parameter int ADDR_W  = 64,
  parameter int MAX_LEN = 3584,
  parameter int LEN_W   = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic              resume_i,
  output logic              busy_o,
  output logic [ADDR_W-1:0] cur_addr_o,
  output logic              err_o,
  output logic              done_o,
  output logic              empty_o,
  output logic              stream_valid_o,
  output logic [31:0]       stream_data_o,
  output logic              stream_last_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [3:0]        mem_be_o,
  output logic [31:0]       mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [31:0]       mem_rdata_i
);
  localparam int                 BE_W      = DQ_WORD_W / 8;
  localparam int                 IDX_W     = $clog2(DQ_DESC_WORDS);
  localparam logic [IDX_W-1:0]   LAST_IDX  = IDX_W'(DQ_DESC_WORDS - 1);
  localparam logic [ADDR_W-1:0]  DESC_MASK = ~ADDR_W'(15);
  localparam logic [ADDR_W-1:0]  WORD_MASK = ~ADDR_W'(BE_W - 1);

  dq_state_e         state_q;
  logic [ADDR_W-1:0] cur_q, baddr_q;
  logic [IDX_W-1:0]  idx_q;
  logic [LEN_W-1:0]  rem_q, len_words;
  logic              err_q, done_q, empty_q, sv_q, sl_q, len_ok;
  logic [31:0]       sd_q;
  dq_desc_t          desc;
  logic              cap;
  logic [IDX_W-1:0]  cap_idx;

  assign cap     = mem_ack_i && (state_q == ST_HDR || state_q == ST_DESC);
  assign cap_idx = (state_q == ST_HDR) ? '0 : idx_q;

  dq_desc_regs #(.IDX_W(IDX_W)) u_desc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cap_i  (cap),
    .idx_i  (cap_idx),
    .data_i (mem_rdata_i),
    .desc_o (desc)
  );

  dq_len_check #(.LEN_W(LEN_W), .MAX_LEN(MAX_LEN), .BYTES_W(BE_W)) u_len (
    .len_i   (desc.buf_len[LEN_W-1:0]),
    .ok_o    (len_ok),
    .words_o (len_words)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cur_q   <= '0;
      baddr_q <= '0;
      idx_q   <= '0;
      rem_q   <= '0;
      err_q   <= 1'b0;
      done_q  <= 1'b0;
      empty_q <= 1'b0;
      sv_q    <= 1'b0;
      sl_q    <= 1'b0;
      sd_q    <= '0;
    end else begin
      done_q  <= 1'b0;
      empty_q <= 1'b0;
      sv_q    <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            cur_q   <= start_addr_i & DESC_MASK;
            err_q   <= 1'b0;
            state_q <= ST_HDR;
          end else if (resume_i) begin
            err_q   <= 1'b0;
            state_q <= ST_HDR;
          end
        end
        ST_HDR: begin
          if (mem_ack_i) begin
            if (!mem_rdata_i[DQ_FLAG_OWN]) begin
              empty_q <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              idx_q   <= IDX_W'(1);
              state_q <= ST_DESC;
            end
          end
        end
        ST_DESC: begin
          if (mem_ack_i) begin
            if (idx_q == LAST_IDX) state_q <= ST_CHK;
            else                   idx_q   <= idx_q + IDX_W'(1);
          end
        end
        ST_CHK: begin
          if (!len_ok) begin
            err_q   <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            baddr_q <= desc.buf_ptr[ADDR_W-1:0] & WORD_MASK;
            rem_q   <= len_words;
            state_q <= ST_BUF;
          end
        end
        ST_BUF: begin
          if (mem_ack_i) begin
            sv_q    <= 1'b1;
            sd_q    <= mem_rdata_i;
            sl_q    <= (rem_q == LEN_W'(1));
            baddr_q <= baddr_q + ADDR_W'(BE_W);
            rem_q   <= rem_q - LEN_W'(1);
            if (rem_q == LEN_W'(1)) state_q <= ST_WB;
          end
        end
        ST_WB: begin
          if (mem_ack_i) begin
            done_q  <= desc.flags[DQ_FLAG_IOC];
            cur_q   <= desc.next_ptr[ADDR_W-1:0] & DESC_MASK;
            state_q <= ST_HDR;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    case (state_q)
      ST_DESC: mem_addr_o = cur_q + ADDR_W'({idx_q, 2'b00});
      ST_BUF:  mem_addr_o = baddr_q;
      default: mem_addr_o = cur_q;
    endcase
  end

  assign mem_req_o   = (state_q == ST_HDR) || (state_q == ST_DESC) ||
                       (state_q == ST_BUF) || (state_q == ST_WB);
  assign mem_we_o    = (state_q == ST_WB);
  assign mem_be_o    = mem_we_o ? 4'b0001 : 4'b1111;
  // only byte 0 is enabled; upper bytes are don't-care
  assign mem_wdata_o = {desc.rx_len, 8'h00,
                        desc.flags & ~(8'h01 << DQ_FLAG_OWN)};

  assign busy_o         = (state_q != ST_IDLE);
  assign cur_addr_o     = cur_q;
  assign err_o          = err_q;
  assign done_o         = done_q;
  assign empty_o        = empty_q;
  assign stream_valid_o = sv_q;
  assign stream_data_o  = sd_q;
  assign stream_last_o  = sl_q;
endmodule

// File: rtl/dq_queue_engine_chk.sv
module dq_queue_engine_chk #(
  parameter int ADDR_W = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_o,
  input logic              err_o,
  input logic              done_o,
  input logic              empty_o,
  input logic              stream_valid_o,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [3:0]        mem_be_o,
  input logic [31:0]       mem_wdata_o,
  input logic              mem_ack_i
);
  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_req_o);
  // R3
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));
  // R4
  stream_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stream_valid_o |-> $past(mem_req_o && !mem_we_o && mem_ack_i));
  // R4
  pulse_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({done_o, empty_o, stream_valid_o}));
  // R5
  wb_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o) |-> (mem_be_o == 4'b0001 && !mem_wdata_o[0]));
  // R7
  wb_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o) |-> (mem_addr_o[3:0] == 4'h0));
  // R6
  done_after_wb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(mem_req_o && mem_we_o && mem_ack_i));
  // R8
  empty_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> (!busy_o && !err_o));
  // R10
  err_halt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !busy_o);
endmodule

bind dq_queue_engine dq_queue_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .busy_o         (busy_o),
  .err_o          (err_o),
  .done_o         (done_o),
  .empty_o        (empty_o),
  .stream_valid_o (stream_valid_o),
  .mem_req_o      (mem_req_o),
  .mem_we_o       (mem_we_o),
  .mem_addr_o     (mem_addr_o),
  .mem_be_o       (mem_be_o),
  .mem_wdata_o    (mem_wdata_o),
  .mem_ack_i      (mem_ack_i)
);

// File: tb/dq_queue_engine_tb.sv
`timescale 1ns/1ps
module dq_queue_engine_tb;
  localparam int MAXL   = 64;
  localparam int ADDR_W = 64;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, start, resume;
  logic [ADDR_W-1:0] start_addr;
  logic busy_o, err_o, done_o, empty_o, stream_valid_o, stream_last_o;
  logic [ADDR_W-1:0] cur_addr_o, mem_addr_o;
  logic [31:0] stream_data_o, mem_wdata_o, mem_rdata;
  logic mem_req_o, mem_we_o, mem_ack;
  logic [3:0] mem_be_o;

  dq_queue_engine #(.ADDR_W(ADDR_W), .MAX_LEN(MAXL)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .start_addr_i(start_addr),
    .resume_i(resume), .busy_o(busy_o), .cur_addr_o(cur_addr_o), .err_o(err_o),
    .done_o(done_o), .empty_o(empty_o), .stream_valid_o(stream_valid_o),
    .stream_data_o(stream_data_o), .stream_last_o(stream_last_o),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_be_o(mem_be_o), .mem_wdata_o(mem_wdata_o), .mem_ack_i(mem_ack),
    .mem_rdata_i(mem_rdata));

  logic [31:0] mem [0:2047];
  int errs = 0, checks = 0;
  int done_n = 0, empty_n = 0;
  int unsigned wait_c = 0;
  logic [31:0] got_d[$], exp_d[$];
  logic        got_l[$], exp_l[$];

  // memory model: random latency, one-cycle ack
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ack = 1'b0;
    end else if (mem_ack) begin
      mem_ack = 1'b0;
    end else if (mem_req_o) begin
      if (wait_c == 0) begin
        if (mem_we_o) begin
          for (int b = 0; b < 4; b++)
            if (mem_be_o[b]) mem[mem_addr_o[12:2]][8*b +: 8] = mem_wdata_o[8*b +: 8];
        end else begin
          mem_rdata = mem[mem_addr_o[12:2]];
        end
        mem_ack = 1'b1;
        wait_c = $urandom_range(0, 2);
      end else begin
        wait_c--;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (stream_valid_o) begin
        got_d.push_back(stream_data_o);
        got_l.push_back(stream_last_o);
      end
      if (done_o) done_n++;
      if (empty_o) empty_n++;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic put_desc(input int a, input logic [7:0] fl, input logic [63:0] nx,
                          input logic [63:0] bp, input logic [15:0] ln);
    mem[a/4]     = {16'hABCD, 8'h5A, fl};
    mem[a/4 + 1] = nx[63:32];
    mem[a/4 + 2] = nx[31:0];
    mem[a/4 + 3] = bp[63:32];
    mem[a/4 + 4] = bp[31:0];
    mem[a/4 + 5] = {16'hC3C3, ln};
  endtask

  function automatic int nwords(input int ln);
    return (ln + 3) / 4;
  endfunction

  task automatic exp_buf(input int bp, input int ln);
    for (int i = 0; i < nwords(ln); i++) begin
      exp_d.push_back(mem[(bp & ~3) / 4 + i]);
      exp_l.push_back(i == nwords(ln) - 1);
    end
  endtask

  task automatic cmp_stream(input string tag);
    chk({tag, " beats"}, 64'(got_d.size()), 64'(exp_d.size()));
    if (got_d.size() == exp_d.size())
      for (int i = 0; i < exp_d.size(); i++) begin
        chk({tag, " data"}, 64'(got_d[i]), 64'(exp_d[i]));
        chk({tag, " last"}, 64'(got_l[i]), 64'(exp_l[i]));
      end
    got_d.delete(); got_l.delete(); exp_d.delete(); exp_l.delete();
  endtask

  task automatic wait_idle();
    int n = 0;
    repeat (2) @(negedge clk);
    while (busy_o && n < 5000) begin
      @(negedge clk);
      n++;
    end
    if (n >= 5000) chk("idle watchdog", 64'd1, 64'd0);
    @(negedge clk);
  endtask

  task automatic kick(input bit is_start, input logic [63:0] a);
    done_n = 0; empty_n = 0;
    @(negedge clk);
    start = is_start; resume = !is_start; start_addr = a;
    @(negedge clk);
    start = 1'b0; resume = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [7:0] fl[4];
    int ad[5];
    void'($urandom(32'h1d0c5eed));
    rst_n = 1'b0; start = 1'b0; resume = 1'b0; start_addr = '0;
    mem_ack = 1'b0; mem_rdata = '0;
    for (int i = 0; i < 2048; i++) mem[i] = (i >= 1024) ? $urandom : 32'h0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy", 64'(busy_o), 0);
    chk("R1 err", 64'(err_o), 0);
    chk("R1 cur", cur_addr_o, 0);
    chk("R1 req", 64'(mem_req_o), 0);
    chk("R1 pulses", 64'({done_o, empty_o, stream_valid_o}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2 R3 R4 R5 R6 R7 R8: directed three-entry chain
    put_desc(32'h100, 8'hBD, 64'h205, 64'h1002, 16'd10);
    put_desc(32'h200, 8'h01, 64'h300, 64'h1100, 16'd4);
    put_desc(32'h300, 8'h80, 64'h100, 64'h1200, 16'd8);
    exp_buf(32'h1002, 10);
    exp_buf(32'h1100, 4);
    kick(1'b1, 64'h10B);
    wait_idle();
    cmp_stream("R4 chain");
    chk("R6 done count", 64'(done_n), 1);
    chk("R8 empty count", 64'(empty_n), 1);
    chk("R7 cur at halt", cur_addr_o, 64'h300);
    chk("R5 writeback d0", 64'(mem[32'h100/4]), 64'h ABCD5ABC);
    chk("R5 writeback d1", 64'(mem[32'h200/4]), 64'h ABCD5A00);
    chk("R8 no writeback", 64'(mem[32'h300/4]), 64'h ABCD5A80);
    chk("R8 busy", 64'(busy_o), 0);

    // R9 resume from current address, not start
    put_desc(32'h300, 8'h81, 64'h100, 64'h1200, 16'd8);
    exp_buf(32'h1200, 8);
    kick(1'b0, 64'h0);
    wait_idle();
    cmp_stream("R9 resume");
    chk("R9 done", 64'(done_n), 1);
    chk("R9 empty", 64'(empty_n), 1);
    chk("R9 cur", cur_addr_o, 64'h100);

    // R10 zero length
    put_desc(32'h400, 8'h81, 64'h500, 64'h1300, 16'd0);
    mem[32'h500/4] = 32'h0;
    kick(1'b1, 64'h400);
    wait_idle();
    cmp_stream("R10 zero len");
    chk("R10 err zero", 64'(err_o), 1);
    chk("R10 cur zero", cur_addr_o, 64'h400);
    chk("R10 owned kept", 64'(mem[32'h400/4]), 64'h ABCD5A81);
    chk("R10 no empty", 64'(empty_n), 0);
    // R10 one above limit
    mem[32'h400/4 + 5] = {16'hC3C3, 16'(MAXL + 1)};
    kick(1'b0, 64'h0);
    wait_idle();
    cmp_stream("R10 over len");
    chk("R10 err over", 64'(err_o), 1);
    chk("R10 cur over", cur_addr_o, 64'h400);
    // R10 limit accepted, R11 start while busy ignored
    mem[32'h400/4 + 5] = {16'hC3C3, 16'(MAXL)};
    put_desc(32'h600, 8'h81, 64'h500, 64'h1400, 16'd4);
    exp_buf(32'h1300, MAXL);
    kick(1'b0, 64'h0);
    repeat (4) @(negedge clk);
    start = 1'b1; start_addr = 64'h600;
    @(negedge clk);
    start = 1'b0;
    wait_idle();
    cmp_stream("R10 limit len");
    chk("R10 err cleared", 64'(err_o), 0);
    chk("R11 cur after busy start", cur_addr_o, 64'h500);
    chk("R11 done", 64'(done_n), 1);

    // random chains
    for (int it = 0; it < 20; it++) begin
      int k, s, nd;
      k = $urandom_range(1, 4);
      s = $urandom_range(0, 63);
      nd = 0;
      for (int j = 0; j <= k; j++) ad[j] = ((s + j) % 64) * 32;
      for (int j = 0; j < k; j++) begin
        int ln, bp;
        ln = $urandom_range(1, MAXL);
        bp = 32'h1000 + j * 32'h100 + $urandom_range(0, 3);
        fl[j] = {1'($urandom), 6'($urandom), 1'b1};
        if (fl[j][7]) nd++;
        for (int w = 0; w < 16; w++) mem[(32'h1000 + j * 32'h100) / 4 + w] = $urandom;
        put_desc(ad[j], fl[j], 64'(ad[j + 1] + $urandom_range(0, 15)), 64'(bp), 16'(ln));
        exp_buf(bp, ln);
      end
      mem[ad[k] / 4] = {24'h0, 8'($urandom) & 8'hFE};
      kick(1'b1, 64'(ad[0] + $urandom_range(0, 15)));
      wait_idle();
      cmp_stream("R4 random");
      chk("R6 random done", 64'(done_n), 64'(nd));
      chk("R8 random empty", 64'(empty_n), 1);
      chk("R7 random cur", cur_addr_o, 64'(ad[k]));
      for (int j = 0; j < k; j++)
        chk("R5 random wb", 64'(mem[ad[j] / 4]), 64'({16'hABCD, 8'h5A, fl[j] & 8'hFE}));
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule